// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block takes one decoded instruction's addressing information and produces the operand value together with the address it came from. The inputs are a 4-bit mode code, a 16-bit address field, a 3-bit register selector and the current program counter. The block reads its own eight-entry register file and issues word reads on a single-port memory request/acknowledge interface. Depending on the mode it makes zero, one or two reads. In the two-read modes, the first read returns a pointer that forms the address of the second read.

A `start` pulse is accepted only in state IDLE. From IDLE the sequencer moves to one of three states: FETCH_PTR when the mode needs a pointer lookup, FETCH_OPND when it needs a single operand read, or FINISH when no read is needed or the mode code is undefined. FETCH_PTR moves to FETCH_OPND on acknowledge. FETCH_OPND moves to FINISH on acknowledge. FINISH raises `done` for one cycle and returns to IDLE. The operand and effective address outputs hold their values until the next FINISH. A write port loads the register file.

Top module: `ea_gen`

## Requirements
- R1: Mode 0 (immediate) gives operand = address field and eff_addr = 0, with no memory read. `done` is high in the cycle after the start edge.
- R2: Mode 1 (direct) reads memory once at the address field. The returned word is the operand and the address field is the effective address.
- R3: Mode 2 (memory-indirect) reads at the address field to get a pointer, then reads the operand at that pointer. The pointer is the effective address.
- R4: Mode 3 (register) gives operand = selected register and eff_addr = 0, with no read. Mode 4 (register-indirect) reads once at the address held in the selected register.
- R5: Mode 5 (displacement) reads once at address field + selected register.
- R6: Mode 6 (PC-relative) reads once at address field + pc.
- R7: Mode 7 (indexed auto-increment) reads once at address field + selected register, using the register's old value. The register holds its old value + 1 for every later instruction.
- R8: Mode 8 (pre-index indirect) reads a pointer at address field + register, then reads the operand at the pointer.
- R9: Mode 9 (post-index indirect) reads at the address field, adds the register to the returned word, then reads the operand at that sum.
- R10: Every address sum and the auto-increment wrap modulo 2^16.
- R11: `mem_req` stays high with a stable `mem_addr` until `mem_ack`. Only one read is outstanding at a time. With a memory latency of L cycles per read, `done` comes N·L cycles after the start cycle for N reads, and lasts one cycle.
- R12: Mode codes 10 to 15 raise `error` for one cycle together with `done`, in the cycle after the start edge. They make no read, leave the registers unchanged, and report operand = eff_addr = 0.
- R13: A `start` pulse arriving while an access is in progress is ignored.
- R14: A register-file write with `rf_we` high is visible to any instruction started in a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one address computation |
| mode | input | 4 | Addressing mode code |
| addr_field | input | 16 | Address field of the instruction |
| reg_sel | input | 3 | Register selector |
| pc | input | 16 | Current program counter |
| rf_we | input | 1 | Register-file write enable |
| rf_wsel | input | 3 | Register-file write index |
| rf_wdata | input | 16 | Register-file write data |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_ack | input | 1 | Read data valid, request complete |
| mem_rdata | input | 16 | Read data |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Undefined mode code, valid with done |
| operand | output | 16 | Fetched operand |
| eff_addr | output | 16 | Effective address of the operand |

## Verification
The bench builds the block with its default parameters: 16-bit words and eight registers. At this width, sums that cross 0xFFFF and an increment of 0xFFFF are reachable, and every register index can be exercised. The bench's memory answers after one to three cycles, so the read count and the N·L completion time are checked for every mode, at several latencies. Pointer chains use a memory content computed from the address, so a wrong pointer address shows up as a wrong operand.

// File: rtl/ea_pkg.sv
package ea_pkg;
    typedef enum logic [3:0] {
        M_IMM     = 4'd0,
        M_DIR     = 4'd1,
        M_IND     = 4'd2,
        M_REG     = 4'd3,
        M_RIND    = 4'd4,
        M_DISP    = 4'd5,
        M_REL     = 4'd6,
        M_IDXINC  = 4'd7,
        M_PREIDX  = 4'd8,
        M_POSTIDX = 4'd9
    } ea_mode_e;

    typedef enum logic [1:0] {
        S_IDLE      = 2'd0,
        S_FETCH_PTR = 2'd1,
        S_FETCH_OPND = 2'd2,
        S_FINISH    = 2'd3
    } ea_state_e;
endpackage

// File: rtl/ea_regfile.sv
module ea_regfile #(
    parameter int DW   = 16,
    parameter int NREG = 8,
    localparam int SW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] rd_sel,
    output logic [DW-1:0] rd_data,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          inc_en,
    input  logic [SW-1:0] inc_sel
);
    logic [DW-1:0] regs [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (inc_en && inc_sel == SW'(i)) begin
                regs[i] <= regs[i] + DW'(1);
            end else if (wr_en && wr_sel == SW'(i)) begin
                regs[i] <= wr_data;
            end
        end
    end

    assign rd_data = regs[rd_sel];

    // R7
    inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc_en |=> (regs[$past(inc_sel)] == $past(regs[inc_sel]) + DW'(1)));
endmodule

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
    import ea_pkg::*;
#(
    parameter int AW = 16
) (
    input  ea_mode_e      mode,
    input  logic [3:0]    mode_raw,
    input  logic [AW-1:0] field,
    input  logic [AW-1:0] rval,
    input  logic [AW-1:0] pc,
    output logic [AW-1:0] first_addr,
    output logic [1:0]    n_reads,
    output logic [AW-1:0] direct_val,
    output logic          bad,
    output logic          bump
);
    always_comb begin
        first_addr = '0;
        n_reads    = 2'd0;
        direct_val = '0;
        bad        = 1'b0;
        bump       = 1'b0;
        if (mode_raw > 4'd9) begin
            bad = 1'b1;
        end else begin
            unique case (mode)
                M_IMM:     direct_val = field;
                M_REG:     direct_val = rval;
                M_DIR:     begin first_addr = field;        n_reads = 2'd1; end
                M_RIND:    begin first_addr = rval;         n_reads = 2'd1; end
                M_DISP:    begin first_addr = field + rval; n_reads = 2'd1; end
                M_REL:     begin first_addr = field + pc;   n_reads = 2'd1; end
                M_IDXINC:  begin first_addr = field + rval; n_reads = 2'd1; bump = 1'b1; end
                M_IND:     begin first_addr = field;        n_reads = 2'd2; end
                M_POSTIDX: begin first_addr = field;        n_reads = 2'd2; end
                M_PREIDX:  begin first_addr = field + rval; n_reads = 2'd2; end
                default:   bad = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/ea_fsm.sv
module ea_fsm
    import ea_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  ea_mode_e      mode,
    input  logic [AW-1:0] rval,
    input  logic [AW-1:0] first_addr,
    input  logic [1:0]    n_reads,
    input  logic [AW-1:0] direct_val,
    input  logic          bad,
    input  logic          bump,
    output logic          inc_fire,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_ack,
    input  logic [AW-1:0] mem_rdata,
    output logic          done,
    output logic          error,
    output logic [AW-1:0] operand,
    output logic [AW-1:0] eff_addr
);
    ea_state_e     state, nxt;
    ea_mode_e      mode_q;
    logic [AW-1:0] rval_q, addr_q, op_q, ea_q;
    logic          err_q;
    logic          accept;

    assign accept = (state == S_IDLE) && start;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    if (bad || n_reads == 2'd0) nxt = S_FINISH;
                    else if (n_reads == 2'd2)   nxt = S_FETCH_PTR;
                    else                        nxt = S_FETCH_OPND;
                end
            end
            S_FETCH_PTR:  if (mem_ack) nxt = S_FETCH_OPND;
            S_FETCH_OPND: if (mem_ack) nxt = S_FINISH;
            S_FINISH:     nxt = S_IDLE;
            default:      nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= M_IMM;
            rval_q <= '0;
            addr_q <= '0;
            op_q   <= '0;
            ea_q   <= '0;
            err_q  <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        mode_q <= mode;
                        rval_q <= rval;
                        addr_q <= first_addr;
                        err_q  <= bad;
                        if (bad || n_reads == 2'd0) begin
                            op_q <= bad ? '0 : direct_val;
                            ea_q <= '0;
                        end
                    end
                end
                S_FETCH_PTR: begin
                    if (mem_ack)
                        addr_q <= mem_rdata + ((mode_q == M_POSTIDX) ? rval_q : '0);
                end
                S_FETCH_OPND: begin
                    if (mem_ack) begin
                        op_q <= mem_rdata;
                        ea_q <= addr_q;
                    end
                end
                default: ;
            endcase
        end
    end

    assign inc_fire = accept && bump && !bad;
    assign mem_req  = (state == S_FETCH_PTR) || (state == S_FETCH_OPND);
    assign mem_addr = addr_q;
    assign done     = (state == S_FINISH);
    assign error    = (state == S_FINISH) && err_q;
    assign operand  = op_q;
    assign eff_addr = ea_q;

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req);
    // R11
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> $stable(mem_addr));
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R12
    err_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error) |-> ($past(start) && !$past(mem_req)));
endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_pkg::*;
#(
    parameter int AW   = 16,
    parameter int NREG = 8,
    localparam int SW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    mode,
    input  logic [AW-1:0] addr_field,
    input  logic [SW-1:0] reg_sel,
    input  logic [AW-1:0] pc,
    input  logic          rf_we,
    input  logic [SW-1:0] rf_wsel,
    input  logic [AW-1:0] rf_wdata,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_ack,
    input  logic [AW-1:0] mem_rdata,
    output logic          done,
    output logic          error,
    output logic [AW-1:0] operand,
    output logic [AW-1:0] eff_addr
);
    ea_mode_e      mode_e;
    logic [AW-1:0] rval, first_addr, direct_val;
    logic [1:0]    n_reads;
    logic          bad, bump, inc_fire;

    assign mode_e = ea_mode_e'(mode);

    ea_regfile #(.DW(AW), .NREG(NREG)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .rd_sel(reg_sel), .rd_data(rval),
        .wr_en(rf_we), .wr_sel(rf_wsel), .wr_data(rf_wdata),
        .inc_en(inc_fire), .inc_sel(reg_sel)
    );

    ea_addr_calc #(.AW(AW)) u_calc (
        .mode(mode_e), .mode_raw(mode), .field(addr_field), .rval(rval), .pc(pc),
        .first_addr(first_addr), .n_reads(n_reads), .direct_val(direct_val),
        .bad(bad), .bump(bump)
    );

    ea_fsm #(.AW(AW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode_e), .rval(rval),
        .first_addr(first_addr), .n_reads(n_reads), .direct_val(direct_val),
        .bad(bad), .bump(bump), .inc_fire(inc_fire),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .error(error), .operand(operand), .eff_addr(eff_addr)
    );
endmodule

// File: tb/ea_gen_tb.sv
module ea_gen_tb;
    logic        clk = 0, rst_n = 0, start = 0;
    logic [3:0]  mode = 0;
    logic [15:0] addr_field = 0, pc = 0, rf_wdata = 0, mem_rdata = 0;
    logic [2:0]  reg_sel = 0, rf_wsel = 0;
    logic        rf_we = 0, mem_ack = 0;
    logic        mem_req, done, error;
    logic [15:0] mem_addr, operand, eff_addr;

    int checks = 0, failures = 0;
    int lat = 1, acks = 0, wcnt = 0;
    logic [15:0] mregs [8];
    logic        prev_req = 0, prev_ack = 0;
    logic [15:0] prev_addr = 0;

    ea_gen u_dut (.*);

    always #5 clk = ~clk;

    function automatic logic [15:0] memf(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h5A3C;
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // memory responder and handshake monitor (R11)
    initial forever begin
        @(negedge clk);
        if (rst_n && prev_req && !prev_ack && mem_req)
            chk(mem_addr == prev_addr, "R11 addr stable", mem_addr, prev_addr);
        prev_req = mem_req; prev_addr = mem_addr;
        mem_ack = 0;
        if (rst_n && mem_req) begin
            wcnt++;
            if (wcnt >= lat) begin
                mem_ack = 1; mem_rdata = memf(mem_addr); wcnt = 0; acks++;
            end
        end
        prev_ack = mem_ack;
    end

    initial begin
        #1_500_000;
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic wr_reg(input logic [2:0] s, input logic [15:0] v);
        @(negedge clk); rf_we = 1; rf_wsel = s; rf_wdata = v;
        @(negedge clk); rf_we = 0;
        mregs[s] = v;
    endtask

    task automatic do_op(input logic [3:0] m, input logic [15:0] fld, input logic [2:0] s,
                         input logic [15:0] pcv, input int lt, input bit poke, input string rq);
        logic [15:0] r, eop, eea;
        bit eerr;
        int nrd, cyc;
        r = mregs[s]; eop = 0; eea = 0; eerr = 0; nrd = 0;
        case (m)
            4'd0: eop = fld;
            4'd1: begin eea = fld; nrd = 1; end
            4'd2: begin eea = memf(fld); nrd = 2; end
            4'd3: eop = r;
            4'd4: begin eea = r; nrd = 1; end
            4'd5: begin eea = fld + r; nrd = 1; end
            4'd6: begin eea = fld + pcv; nrd = 1; end
            4'd7: begin eea = fld + r; nrd = 1; end
            4'd8: begin eea = memf(16'(fld + r)); nrd = 2; end
            4'd9: begin eea = memf(fld) + r; nrd = 2; end
            default: eerr = 1;
        endcase
        if (nrd > 0) eop = memf(eea);
        lat = lt;
        @(negedge clk);
        acks = 0;
        start = 1; mode = m; addr_field = fld; reg_sel = s; pc = pcv;
        @(negedge clk);
        start = 0; cyc = 0;
        if (poke) begin start = 1; mode = 4'd0; addr_field = 16'hDEAD; end
        while (!done && cyc < 40) begin
            chk(error == 0, {rq, " no early error"}, 16'(error), 16'h0);
            @(negedge clk);
            start = 0;
            cyc++;
        end
        start = 0;
        chk(cyc == nrd * lt, {rq, " R11 latency"}, 16'(cyc), 16'(nrd * lt));
        chk(acks == nrd, {rq, " read count"}, 16'(acks), 16'(nrd));
        chk(operand == eop, {rq, " operand"}, operand, eop);
        chk(eff_addr == eea, {rq, " eff_addr"}, eff_addr, eea);
        chk(error == eerr, {rq, " error"}, 16'(error), 16'(eerr));
        @(negedge clk);
        chk(done == 0 && error == 0, {rq, " R11 one-cycle done"}, 16'({done, error}), 16'h0);
        chk(mem_req == 0, {rq, " idle after done"}, 16'(mem_req), 16'h0);
        if (m == 4'd7) mregs[s] = r + 16'd1;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) mregs[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(done == 0 && mem_req == 0 && error == 0, "reset outputs", 16'({done, mem_req, error}), 16'h0);
        chk(operand == 0 && eff_addr == 0, "reset data", operand | eff_addr, 16'h0);

        // R14 register loading
        for (int i = 0; i < 8; i++) wr_reg(3'(i), 16'h1000 + 16'(i * 16'h0111));
        wr_reg(3'd6, 16'hFFFF);
        wr_reg(3'd5, 16'h0020);
        do_op(4'd3, 16'h0, 3'd2, 16'h0, 1, 0, "R14 write visible");
        do_op(4'd0, 16'hBEEF, 3'd0, 16'h0, 1, 0, "R1 immediate");
        do_op(4'd1, 16'h1234, 3'd0, 16'h0, 1, 0, "R2 direct L1");
        do_op(4'd1, 16'h00FF, 3'd0, 16'h0, 3, 0, "R2 direct L3");
        do_op(4'd2, 16'h4321, 3'd0, 16'h0, 2, 0, "R3 mem-indirect");
        do_op(4'd3, 16'h0, 3'd7, 16'h0, 1, 0, "R4 register");
        do_op(4'd4, 16'h0, 3'd3, 16'h0, 2, 0, "R4 register-indirect");
        do_op(4'd5, 16'h0042, 3'd1, 16'h0, 1, 0, "R5 displacement");
        do_op(4'd6, 16'h0010, 3'd0, 16'h2200, 2, 0, "R6 relative");
        do_op(4'd7, 16'h0100, 3'd4, 16'h0, 1, 0, "R7 auto-inc");
        do_op(4'd3, 16'h0, 3'd4, 16'h0, 1, 0, "R7 register bumped");
        do_op(4'd8, 16'h0300, 3'd2, 16'h0, 1, 0, "R8 pre-index");
        do_op(4'd9, 16'h0777, 3'd1, 16'h0, 3, 0, "R9 post-index");
        do_op(4'd5, 16'hFFF0, 3'd5, 16'h0, 1, 0, "R10 wrap disp");
        do_op(4'd6, 16'hF000, 3'd0, 16'h3000, 1, 0, "R10 wrap relative");
        do_op(4'd7, 16'h0005, 3'd6, 16'h0, 2, 0, "R10 auto-inc wrap");
        do_op(4'd3, 16'h0, 3'd6, 16'h0, 1, 0, "R10 register wrapped to 0");
        do_op(4'd8, 16'hFFFF, 3'd5, 16'h0, 2, 0, "R10 pre-index wrap");
        for (int c = 10; c < 16; c++) begin
            do_op(4'(c), 16'h0123, 3'd4, 16'h0, 1, 0, "R12 undefined mode");
            do_op(4'd3, 16'h0, 3'd4, 16'h0, 1, 0, "R12 register unchanged");
        end
        do_op(4'd2, 16'h0ABC, 3'd0, 16'h0, 2, 1, "R13 busy start ignored");
        do_op(4'd9, 16'h5555, 3'd7, 16'h0, 1, 1, "R13 busy start post-index");
        do_op(4'd0, 16'h7777, 3'd0, 16'h0, 1, 0, "R13 next op runs");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule